// File: doc/BRIEF.md
# Decimal-to-BCD Priority Encoder

This block takes nine decimal request lines, numbered 1 to 9, and reports the highest-numbered line that is pulled low as a 4-bit 8-4-2-1 BCD digit. Both the requests and the result are active low, so the code that leaves the block is the bitwise complement of the decimal value. Decimal zero has no request line of its own. It is the value reported when every line is high.

A typical use is a keypad or range-select front end. Several lines may be low at the same time, and only the highest one counts. A generate-time parameter selects the output path. In the registered variant, the code is captured on the rising clock edge and a synchronous active-high reset forces it to the zero code. In the combinational variant, the code follows the request lines directly.

Top module: `dec_bcd_encoder`

## Requirements
- R1: Each of the request lines `req_n[8:0]` stands for digit bit-index+1, so bit 0 is digit 1 and bit 8 is digit 9. A low level asserts that digit, and the result encodes the highest asserted digit.
- R2: When all nine request lines are high, `code_n` is 4'b1111, which is decimal zero.
- R3: When line 9 (`req_n[8]`) is low, `code_n` is 4'b0110 whatever the other lines carry.
- R4: When line 1 (`req_n[0]`) is the only low line, `code_n` is 4'b1110.
- R5: Lines below the highest asserted one have no effect on `code_n`.
- R6: `code_n` is the bitwise inverse of the BCD digit. Bit 3 carries weight 8, bit 2 weight 4, bit 1 weight 2 and bit 0 weight 1.
- R7: With `REG_OUT`=1, `code_n` shows the result for the request lines sampled at the previous rising clock edge, and it holds steady between edges.
- R8: With `REG_OUT`=1, a high `rst` at a rising edge sets `code_n` to 4'b1111 whatever the request lines carry.
- R9: With `REG_OUT`=0, `code_n` follows the request lines with no clock delay, and `rst` has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered output variant |
| rst | input | 1 | Synchronous active-high reset of the output register |
| req_n | input | 9 | Active-low decimal request lines; bit i is digit i+1 |
| code_n | output | 4 | Active-low BCD code of the highest asserted digit |

## Verification
The bench builds two copies of the encoder side by side with the default nine lines: one with `REG_OUT`=1 and one with `REG_OUT`=0. Driving both from the same request lines puts the one-cycle capture and the reset override of the registered path next to the zero-delay path, and the two can be compared in the same cycle. This also shows that reset leaves the combinational copy untouched. All 512 request patterns are swept exhaustively on both copies. A seeded random phase then follows, biased toward sparse low lines.

// File: rtl/dbe_pkg.sv
package dbe_pkg;

  localparam int unsigned DEF_LINES = 9;

  // Width needed to carry the values 0..n.
  function automatic int unsigned code_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/dbe_scan.sv
module dbe_scan #(
  parameter int unsigned NUM_LINES = dbe_pkg::DEF_LINES,
  parameter int unsigned IDX_W     = dbe_pkg::code_width(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] req_n,
  output logic [IDX_W-1:0]     top_idx,
  output logic                 hit
);

  // Ascending scan: the last asserted line seen wins, giving highest priority.
  always_comb begin
    top_idx = '0;
    hit     = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (!req_n[i]) begin
        top_idx = IDX_W'(i + 1);
        hit     = 1'b1;
      end
    end
  end

  // The reported line must itself be asserted (R1).
  always_comb begin
    if (hit) begin
      assert_hit_line_R1: assert (!req_n[top_idx - 1'b1]);
    end
  end

  // No line above the reported one may be asserted (R5).
  always_comb begin
    for (int j = 0; j < NUM_LINES; j++) begin
      if (IDX_W'(j) >= top_idx) begin
        assert_above_clear_R5: assert (req_n[j]);
      end
    end
  end

endmodule

// File: rtl/dbe_pack.sv
module dbe_pack #(
  parameter int unsigned IDX_W = 4
) (
  input  logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] code_n
);

  // Active-low result: the inverse of the binary digit.
  assign code_n = ~idx;

endmodule

// File: rtl/dbe_out_stage.sv
module dbe_out_stage #(
  parameter int unsigned W       = 4,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) q <= '1;
        else     q <= d;
      end
    end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst;
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/dec_bcd_encoder.sv
module dec_bcd_encoder #(
  parameter int unsigned NUM_LINES = dbe_pkg::DEF_LINES,
  parameter bit          REG_OUT   = 1'b1
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic [NUM_LINES-1:0]                         req_n,
  output logic [dbe_pkg::code_width(NUM_LINES)-1:0]    code_n
);

  localparam int unsigned CODE_W = dbe_pkg::code_width(NUM_LINES);
  localparam logic [CODE_W-1:0] TOP_CODE_N  = ~CODE_W'(NUM_LINES);
  localparam logic [CODE_W-1:0] ONE_CODE_N  = ~CODE_W'(1);
  localparam logic [CODE_W-1:0] ZERO_CODE_N = '1;

  logic [CODE_W-1:0] top_idx;
  logic              hit;
  logic [CODE_W-1:0] code_next_n;

  dbe_scan #(
    .NUM_LINES (NUM_LINES),
    .IDX_W     (CODE_W)
  ) scan_i (
    .req_n   (req_n),
    .top_idx (top_idx),
    .hit     (hit)
  );

  dbe_pack #(
    .IDX_W (CODE_W)
  ) pack_i (
    .idx    (top_idx),
    .code_n (code_next_n)
  );

  dbe_out_stage #(
    .W       (CODE_W),
    .REG_OUT (REG_OUT)
  ) out_i (
    .clk (clk),
    .rst (rst),
    .d   (code_next_n),
    .q   (code_n)
  );

  // With no line asserted, the scanner reports index 0 (R2).
  always_comb begin
    if (&req_n) begin
      assert_idle_scan_R2: assert (!hit && top_idx == '0);
    end
  end

  generate
    if (REG_OUT) begin : g_reg_chk
      assert_all_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (&req_n) |=> (code_n == ZERO_CODE_N));

      assert_top_line_R3: assert property (@(posedge clk) disable iff (rst)
        (!req_n[NUM_LINES-1]) |=> (code_n == TOP_CODE_N));

      assert_bottom_only_R4: assert property (@(posedge clk) disable iff (rst)
        ((&req_n[NUM_LINES-1:1]) && !req_n[0]) |=> (code_n == ONE_CODE_N));

      assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        $stable(req_n) |=> $stable(code_n));
    end
  endgenerate

endmodule

// File: tb/dec_bcd_encoder_tb_top.sv
module dec_bcd_encoder_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] req_n = '1;
  logic [3:0] code_reg_n;
  logic [3:0] code_comb_n;

  int n_checks = 0;
  int n_bad    = 0;

  always #4 clk = ~clk;

  dec_bcd_encoder #(.NUM_LINES(9), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .req_n(req_n), .code_n(code_reg_n));

  dec_bcd_encoder #(.NUM_LINES(9), .REG_OUT(1'b0)) dut_comb_i (
    .clk(clk), .rst(rst), .req_n(req_n), .code_n(code_comb_n));

  function automatic logic [3:0] exp_code(input logic [8:0] p);
    for (int d = 9; d >= 1; d--) begin
      if (!p[d-1]) return ~4'(d);
    end
    return 4'b1111;
  endfunction

  function automatic string tag_for(input logic [8:0] p);
    if (&p)              return "R2";
    if (!p[8])           return "R3";
    if (&p[8:1])         return "R4";
    return "R1/R5/R6";
  endfunction

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  logic [8:0] prev_p = '1;

  task automatic apply(input logic [8:0] p);
    @(negedge clk);
    req_n = p;
    #1;
    check({tag_for(p), "/R9"}, code_comb_n, exp_code(p));
    check("R7 hold before edge", code_reg_n, exp_code(prev_p));
    @(posedge clk);
    #1;
    check({tag_for(p), "/R7"}, code_reg_n, exp_code(p));
    prev_p = p;
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] seed_v;
    // Reset with every line asserted: registered output forced to zero code (R8),
    // combinational copy ignores reset (R9).
    rst   = 1'b1;
    req_n = 9'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset state", code_reg_n, 4'b1111);
    check("R9 reset ignored", code_comb_n, 4'b0110);
    req_n = '1;
    @(negedge clk);
    rst = 1'b0;
    prev_p = '1;

    // Directed corners.
    apply(9'b1_1111_1111);          // R2
    apply(9'b0_0000_0000);          // R3
    apply(9'b1_1111_1110);          // R4
    apply(9'b0_1111_1111);          // R3 alone
    apply(9'b1_0101_0101);          // R5: digit 8 wins
    apply(9'b1_1110_0000);          // R5: digit 5 wins

    // Exhaustive sweep of all 512 patterns.
    for (int k = 0; k < 512; k++) apply(9'(k));

    // Seeded random, biased toward few asserted lines.
    seed_v = $urandom(32'd20240611);
    for (int k = 0; k < 200; k++) begin
      logic [8:0] m;
      m = 9'($urandom) | 9'($urandom);
      apply(m);
    end

    // Mid-run reset: R8 overrides a live request.
    @(negedge clk);
    req_n = 9'b1_1011_1111;
    rst   = 1'b1;
    @(posedge clk);
    #1;
    check("R8 mid-run reset", code_reg_n, 4'b1111);
    check("R9 reset ignored mid-run", code_comb_n, ~4'd7);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R7 after reset release", code_reg_n, ~4'd7);

    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule